// File: doc/BRIEF.md
# Per-Source Interrupt Controller

This block gathers event pulses from four parts of a command interface and turns them into a single interrupt line. The four sources are: data available, status valid, a change of the owning locality, and the command interface becoming ready. Each source pulse sets a sticky pending bit. Software clears a pending bit by writing a one to it. The pending bit drives the line only while two things are true: the bit's own source enable is set, and the master enable bit is set.

A small register window holds the configuration:
- an enable word, with one enable per source plus a master enable in the top bit;
- a byte that stores the line number software has chosen;
- the pending word;
- a read-only capability word.

The capability word lists the sources that exist, the one signalling style this build uses, and whether the burst count is static. The signalling style is fixed by a parameter. It is one of level active-high, level active-low, rising-edge pulse or falling-edge pulse.

Reads are combinational from the address while the read strobe is high. Writes take effect on the clock edge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the enable word, the pending word and the vector byte all read 0. The line sits at its idle level: low for the active-high and rising styles, high for the others.
- R2: The enable word is at offset 0x08. The writable bits are bit 0 (data available), bit 1 (status valid), bit 2 (locality change), bit 7 (command ready) and bit 31 (master enable). All other bits read 0.
- R3: The pending word is at offset 0x10 and uses the same bit positions as the enable word. A pulse on a source sets its pending bit whether or not the source is enabled. A set bit holds until it is cleared. With nothing pending, the word reads 0.
- R4: Writing a 1 to a bit of the pending word clears that bit. Writing 0 leaves the bit unchanged.
- R5: When a source pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: While the master enable is 0, the line stays idle, even with sources enabled and pending. Pending bits still latch.
- R7: In a level style, the line is active on the second clock edge after a bit becomes both pending and enabled (master on). It stays active until no such bit remains, and becomes idle one edge after the last one is cleared.
- R8: In an edge style, the line gives a single-cycle active pulse each time a new bit becomes both pending and enabled (master on). Clearing bits gives no pulse.
- R9: The vector byte is at offset 0x0C. It stores bits 7:0 of a write, and bits 31:8 read 0.
- R10: The capability word is at offset 0x14 and ignores writes. Bits 0, 1, 2 and 7 read 1. Exactly one style bit reads 1: bit 3 for level high, bit 4 for level low, bit 5 for rising edge, bit 6 for falling edge. Bit 8 equals the static-burst parameter. The defaults read 0x18F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; gates reg_rdata |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, 0 when reg_rd is low or the offset is unmapped |
| ev_pulse | input | 4 | Source pulses: [0] data available, [1] status valid, [2] locality change, [3] command ready |
| irq_o | output | 1 | Interrupt line, style set by MODE |

## Verification
The assertions check four behaviours on every cycle:
- each source pulse leaves its pending bit set, even against a clear in the same cycle;
- a clear with no competing pulse drops its bit, and no bit falls without a clear;
- the internal fire signal stays low one cycle after the master enable is off;
- in level styles, fire follows the enabled pending set one cycle later.

Only the bench scenarios can show the register map and read masks, the capability value of each style, and the vector's byte width. They also show the exact one-cycle width of edge pulses and the absence of a pulse on clear. A second instance in rising-edge style covers the edge behaviour.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int REG_W = 32;
  localparam int NSRC  = 4;

  // register offsets; software decodes these
  localparam logic [7:0] OFS_EN  = 8'h08;
  localparam logic [7:0] OFS_VEC = 8'h0C;
  localparam logic [7:0] OFS_STS = 8'h10;
  localparam logic [7:0] OFS_CAP = 8'h14;

  localparam int GLB_BIT   = 31;
  localparam int MODE_BIT0 = 3;
  localparam int BURST_BIT = 8;

  typedef enum logic [1:0] {
    SIG_LVL_HI    = 2'd0,
    SIG_LVL_LO    = 2'd1,
    SIG_EDGE_RISE = 2'd2,
    SIG_EDGE_FALL = 2'd3
  } sig_mode_e;

  // word bit position of source index i
  function automatic int src_pos(int i);
    case (i)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 7;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] src_to_word(logic [NSRC-1:0] s);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[src_pos(i)] = s[i];
    return w;
  endfunction

  function automatic logic [NSRC-1:0] word_to_src(logic [REG_W-1:0] w);
    logic [NSRC-1:0] s;
    for (int i = 0; i < NSRC; i++) s[i] = w[src_pos(i)];
    return s;
  endfunction

  function automatic logic is_level(sig_mode_e m);
    return (m == SIG_LVL_HI) || (m == SIG_LVL_LO);
  endfunction

  function automatic logic is_inverted(sig_mode_e m);
    return (m == SIG_LVL_LO) || (m == SIG_EDGE_FALL);
  endfunction

  function automatic logic [REG_W-1:0] caps_word(sig_mode_e m, logic burst);
    logic [REG_W-1:0] w;
    w = src_to_word('1);
    w[MODE_BIT0 + int'(m)] = 1'b1;
    w[BURST_BIT] = burst;
    return w;
  endfunction

  // enabled pending set, gated by master enable
  function automatic logic [NSRC-1:0] gate_src(logic glb, logic [NSRC-1:0] en,
                                               logic [NSRC-1:0] pend);
    return glb ? (en & pend) : '0;
  endfunction

  function automatic logic new_edge(logic [NSRC-1:0] act, logic [NSRC-1:0] prev);
    return |(act & ~prev);
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bit_q <= 1'b0;
      else if (ev[i]) bit_q <= 1'b1;          // event beats a clear
      else if (clr[i]) bit_q <= 1'b0;
    end
    assign pend[i] = bit_q;
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NSRC  = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             vec_we,
  input  logic [31:0]      wdata,
  output logic [NSRC-1:0]  en_src,
  output logic             glb_en,
  output logic [VEC_W-1:0] vec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_src <= '0;
      glb_en <= 1'b0;
    end else if (en_we) begin
      en_src <= irq_pkg::word_to_src(wdata);
      glb_en <= wdata[irq_pkg::GLB_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec <= '0;
    else if (vec_we) vec <= wdata[VEC_W-1:0];
  end

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int                NSRC = 4,
  parameter irq_pkg::sig_mode_e MODE = irq_pkg::SIG_LVL_HI
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] act,
  output logic            fire_q,
  output logic            irq_o
);

  if (irq_pkg::is_level(MODE)) begin : g_level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fire_q <= 1'b0;
      else        fire_q <= |act;
    end
  end else begin : g_edge
    logic [NSRC-1:0] prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        fire_q <= 1'b0;
      end else begin
        prev_q <= act;
        fire_q <= irq_pkg::new_edge(act, prev_q);
      end
    end
  end

  assign irq_o = irq_pkg::is_inverted(MODE) ? ~fire_q : fire_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int                 ADDR_W       = 8,
  parameter int                 VEC_W        = 8,
  parameter logic               BURST_STATIC = 1'b1,
  parameter irq_pkg::sig_mode_e MODE         = irq_pkg::SIG_LVL_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        ev_pulse,
  output logic              irq_o
);

  localparam int NSRC = irq_pkg::NSRC;
  localparam logic [31:0] CAPS = irq_pkg::caps_word(MODE, BURST_STATIC);

  // named internal events
  logic            hit_en, hit_vec, hit_sts, hit_cap;
  logic [NSRC-1:0] clr_src;
  logic [NSRC-1:0] pend_src;
  logic [NSRC-1:0] en_src;
  logic            glb_en;
  logic [NSRC-1:0] act_src;
  logic            fire_q;
  logic [VEC_W-1:0] vec_q;
  logic            unused_bits;

  assign hit_en  = reg_addr == ADDR_W'(irq_pkg::OFS_EN);
  assign hit_vec = reg_addr == ADDR_W'(irq_pkg::OFS_VEC);
  assign hit_sts = reg_addr == ADDR_W'(irq_pkg::OFS_STS);
  assign hit_cap = reg_addr == ADDR_W'(irq_pkg::OFS_CAP);

  assign clr_src = (reg_wr && hit_sts) ? irq_pkg::word_to_src(reg_wdata) : '0;
  assign unused_bits = ^reg_wdata;

  irq_cfg_regs #(.NSRC(NSRC), .VEC_W(VEC_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (reg_wr && hit_en),
    .vec_we (reg_wr && hit_vec),
    .wdata  (reg_wdata),
    .en_src (en_src),
    .glb_en (glb_en),
    .vec    (vec_q)
  );

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_pulse),
    .clr   (clr_src),
    .pend  (pend_src)
  );

  assign act_src = irq_pkg::gate_src(glb_en, en_src, pend_src);

  irq_line_drv #(.NSRC(NSRC), .MODE(MODE)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act_src),
    .fire_q (fire_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_en)
        reg_rdata = irq_pkg::src_to_word(en_src) | (32'(glb_en) << irq_pkg::GLB_BIT);
      else if (hit_vec)
        reg_rdata = 32'(vec_q);
      else if (hit_sts)
        reg_rdata = irq_pkg::src_to_word(pend_src);
      else if (hit_cap)
        reg_rdata = CAPS;
    end
  end

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int   NSRC     = 4,
  parameter logic IS_LEVEL = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ev,
  input logic [NSRC-1:0] clr,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en,
  input logic            glb,
  input logic            fire
);

  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((pend & $past(ev)) == $past(ev)));

  a_r4_w1c_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~ev)) |=> ((pend & $past(clr & ~ev)) == '0));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend & ~clr) & ~pend) == '0));

  a_r6_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |=> !fire);

  if (IS_LEVEL) begin : g_lvl
    a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fire == $past(glb && (|(pend & en)))));
  end

endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .NSRC     (irq_pkg::NSRC),
  .IS_LEVEL (irq_pkg::is_level(MODE))
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .ev   (ev_pulse),
  .clr  (clr_src),
  .pend (pend_src),
  .en   (en_src),
  .glb  (glb_en),
  .fire (fire_q)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  ev_pulse = '0;
  logic [31:0] rdata, rdata_e;
  logic        irq_lvl, irq_edge;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .ev_pulse(ev_pulse), .irq_o(irq_lvl));

  evt_irq_ctrl #(.MODE(irq_pkg::SIG_EDGE_RISE)) u_edge (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_e),
    .ev_pulse(ev_pulse), .irq_o(irq_edge));

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values and compares them
  always @(negedge clk) begin
    if (reg_rd) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read with no expectation actual=0x%08h expected=none", rdata);
      end else begin
        e = sb_q.pop_front();
        chk(rdata, e.val, e.tag);
      end
    end
  end

  // tasks start and end at posedge+1
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic pulse(logic [3:0] v);
    ev_pulse = v;
    step();
    ev_pulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    chk(32'(irq_lvl), 0, "R1 level-high idle");
    chk(32'(irq_edge), 0, "R1 rising idle");
    rd(8'h08, 32'h0, "R1 enable reset");
    rd(8'h10, 32'h0, "R1 pending reset");
    rd(8'h0C, 32'h0, "R1 vector reset");

    // R10 capability word, both styles, write ignored
    reg_rd = 1'b1; reg_addr = 8'h14;
    begin exp_t e; e.val = 32'h0000_018F; e.tag = "R10 caps level-high"; sb_q.push_back(e); end
    #1 chk(rdata_e, 32'h0000_01A7, "R10 caps rising");
    step(); reg_rd = 1'b0;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h0000_018F, "R10 caps after write");

    // R2 enable mask
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h8000_0087, "R2 enable writable bits");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h0, "R2 enable cleared");

    // R9 vector byte
    wr(8'h0C, 32'hABCD_0E05);
    rd(8'h0C, 32'h05, "R9 vector low byte");
    wr(8'h0C, 32'h0F);
    rd(8'h0C, 32'h0F, "R9 vector rewrite");

    // R3 latch while disabled
    pulse(4'b1111);
    rd(8'h10, 32'h87, "R3 all sources latched");
    chk(32'(irq_lvl), 0, "R3 disabled sources stay quiet");

    // R4 write-one-to-clear
    wr(8'h10, 32'h5);
    rd(8'h10, 32'h82, "R4 clear bits 0 and 2");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h82, "R4 zero write no effect");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R3 nothing pending reads 0");

    // R6 master off
    wr(8'h08, 32'h87);
    pulse(4'b0001);
    step(); step();
    chk(32'(irq_lvl), 0, "R6 level quiet with master off");
    chk(32'(irq_edge), 0, "R6 edge quiet with master off");

    // R7/R8 master on with bit 0 already pending
    wr(8'h08, 32'h8000_0087);
    step();
    chk(32'(irq_lvl), 1, "R7 level asserts");
    chk(32'(irq_edge), 1, "R8 edge pulse on enable");
    step();
    chk(32'(irq_lvl), 1, "R7 level holds");
    chk(32'(irq_edge), 0, "R8 pulse one cycle");
    pulse(4'b0010);
    step();
    chk(32'(irq_edge), 1, "R8 pulse on new source");
    wr(8'h10, 32'h1);
    step();
    chk(32'(irq_lvl), 1, "R7 still active with bit 1");
    chk(32'(irq_edge), 0, "R8 no pulse on clear");
    wr(8'h10, 32'h2);
    step();
    chk(32'(irq_lvl), 0, "R7 idle after last clear");
    chk(32'(irq_edge), 0, "R8 no pulse on last clear");

    // R5 event beats clear in the same cycle
    pulse(4'b0100);
    ev_pulse = 4'b0100; reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h4;
    step();
    ev_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(8'h10, 32'h4, "R5 event wins over clear");
    wr(8'h10, 32'h4);
    rd(8'h10, 32'h0, "R4 clear after collision");

    // R6 master dropped while pending
    pulse(4'b1000);
    step();
    chk(32'(irq_lvl), 1, "R7 command-ready asserts");
    wr(8'h08, 32'h87);
    step();
    chk(32'(irq_lvl), 0, "R6 master off silences line");
    rd(8'h10, 32'h80, "R6 pending kept with master off");

    step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule